// File: doc/BRIEF.md
# Write-Only Two-Wire DAC Register Interface

This block is a receive-only slave on a two-wire serial bus (I2C). It oversamples the serial clock and data lines with a fast system clock, cleans them with a synchronizer and a glitch filter, and detects START, repeated START and STOP. It then shifts in bytes and checks the first byte against its own address or the fixed broadcast address. When the address matches, it pulls the data line low during the ninth clock to acknowledge.

After an address match the block takes a stream of two-byte words. The first byte of each word carries the power-down mode and the top four code bits. The second byte carries the low eight code bits. The block changes its two outputs together, and only when a word is complete. Those outputs are a 12-bit DAC code and a 2-bit output mode, and they drive an analog converter outside this block.

Top module: `i2c_dac_write_slave`

## Requirements
- R1: After reset `dac_code` is 0, `pd_mode` is 0 (normal operation) and `sda_pull_low` is 0. They keep these values until the first complete word.
- R2: An address byte whose upper seven bits are 1001_10 followed by the select bit latched from `addr_sel` during reset, with bit 0 (read/write) equal to 0, is acknowledged. `sda_pull_low` is 1 while SCL is high in the ninth clock. Changes of `addr_sel` after reset have no effect.
- R3: Any other address byte, including the matching one with bit 0 set to 1, is not acknowledged. The data bytes that follow, up to the next START, get no acknowledge and leave `dac_code` and `pd_mode` unchanged.
- R4: The address byte 0x90 is acknowledged and opens a write session whatever the latched select bit is.
- R5: The first byte of a word maps bits [5:4] to `pd_mode` (00 normal, 01 1 kΩ to ground, 10 100 kΩ to ground, 11 high impedance) and bits [3:0] to `dac_code[11:8]`; its bits [7:6] are ignored. The second byte gives `dac_code[7:0]`. Both bytes are acknowledged.
- R6: `dac_code` and `pd_mode` change only at the falling SCL edge that ends the acknowledge after the second byte. While SCL is high in that ninth clock, they still hold the previous word.
- R7: Once addressed, any number of words may follow, and each one updates the outputs, until a STOP or repeated START.
- R8: A first byte of the form 0000_1xxx (high-speed preamble) is not acknowledged. A repeated START and a matching address that follow it open a normal session.
- R9: A START or STOP in the middle of a word discards the partial word, leaves the outputs unchanged and releases `sda_pull_low`.
- R10: A pulse on SCL shorter than `FILT_CYCLES` system clocks is ignored and does not count as a bit.
- R11: A repeated START always begins a new address phase. If the new address does not match, the words that follow are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset; `addr_sel` is latched while it is high |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| addr_sel | input | 1 | Address select bit, sampled during reset |
| sda_pull_low | output | 1 | 1 pulls the data line low (open-drain acknowledge) |
| dac_code | output | 12 | Converter code, unsigned binary |
| pd_mode | output | 2 | Output mode: 00 normal, 01 1 kΩ, 10 100 kΩ, 11 high impedance |

## Verification
The bench builds the block with `FILT_CYCLES` = 4 and a bit period of 48 system clocks, so a 2-clock spike is clearly below the filter threshold and every line change is settled well before the next edge. With this setting, all 256 address bytes can be offered under one latched select bit, and the 16 bytes around the device prefix under the other. The acknowledge decision is then checked arithmetically for every address byte. Words with varied codes, modes and junk upper bits check the field mapping and the timing of the update. Aborted words, repeated STARTs and the preamble cover the protocol corner cases.

// File: rtl/dacw_pkg.sv
package dacw_pkg;

    localparam int DAC_W   = 12;
    localparam int PD_W    = 2;
    localparam int BYTE_W  = 8;
    localparam int HI_W    = DAC_W - BYTE_W;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);

    localparam logic [5:0]        DEV_PREFIX = 6'b100110;
    localparam logic [BYTE_W-1:0] BCAST_ADDR = 8'h90;
    localparam logic [4:0]        HS_PREFIX  = 5'b00001;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_ev_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_HI,
        ST_HI_ACK,
        ST_LO,
        ST_LO_ACK,
        ST_HS_WAIT,
        ST_SKIP
    } wr_state_e;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic sel);
        return ((b[7:1] == {DEV_PREFIX, sel}) && !b[0]) || (b == BCAST_ADDR);
    endfunction

    function automatic logic is_hs_code(input logic [BYTE_W-1:0] b);
        return b[7:3] == HS_PREFIX;
    endfunction

endpackage

// File: rtl/dacw_line_filter.sv
module dacw_line_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic [1:0]    sync_q;
    logic          out_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            out_q  <= 1'b1;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] != out_q) begin
                if (cnt_q == CW'(FILT_CYCLES - 1)) begin
                    out_q <= sync_q[1];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign clean = out_q;

    // R10
    filter_follows_sync_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_q) |-> out_q == $past(sync_q[1]));

endmodule

// File: rtl/dacw_bus_events.sv
module dacw_bus_events
    import dacw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic    scl_p, sda_p;
    bus_ev_t ev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
            ev_q  <= '0;
        end else begin
            scl_p         <= scl_f;
            sda_p         <= sda_f;
            ev_q.start    <= scl_f && scl_p && sda_p && !sda_f;
            ev_q.stop     <= scl_f && scl_p && !sda_p && sda_f;
            ev_q.scl_rise <= scl_f && !scl_p;
            ev_q.scl_fall <= !scl_f && scl_p;
            ev_q.sda      <= sda_f;
        end
    end

    assign ev = ev_q;

    // R9
    no_cond_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_q.start || ev_q.stop) |-> !(ev_q.scl_rise || ev_q.scl_fall));

endmodule

// File: rtl/dacw_write_fsm.sv
module dacw_write_fsm
    import dacw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             addr_sel,
    input  bus_ev_t          ev,
    output logic             pull_low,
    output logic [DAC_W-1:0] code,
    output logic [PD_W-1:0]  mode
);
    wr_state_e            state;
    logic [BITCNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0]    shreg;
    logic [HI_W+PD_W-1:0] hi_q;
    logic [BYTE_W-1:0]    lo_q;
    logic                 sel_q;
    logic                 drive_q;
    logic [DAC_W-1:0]     code_q;
    logic [PD_W-1:0]      mode_q;
    logic                 byte_done;

    assign byte_done = ev.scl_fall && (bitcnt == BITCNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            sel_q   <= addr_sel;
            drive_q <= 1'b0;
            code_q  <= '0;
            mode_q  <= '0;
        end else if (ev.start) begin
            state   <= ST_ADDR;
            bitcnt  <= '0;
            drive_q <= 1'b0;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            bitcnt  <= '0;
            drive_q <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_HI, ST_LO: begin
                    if (ev.scl_rise && bitcnt < BITCNT_W'(BYTE_W)) begin
                        shreg  <= {shreg[BYTE_W-2:0], ev.sda};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            if (addr_hit(shreg, sel_q)) begin
                                drive_q <= 1'b1;
                                state   <= ST_ADDR_ACK;
                            end else if (is_hs_code(shreg)) begin
                                state <= ST_HS_WAIT;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end else if (state == ST_HI) begin
                            hi_q    <= shreg[HI_W+PD_W-1:0];
                            drive_q <= 1'b1;
                            state   <= ST_HI_ACK;
                        end else begin
                            lo_q    <= shreg;
                            drive_q <= 1'b1;
                            state   <= ST_LO_ACK;
                        end
                    end
                end
                ST_ADDR_ACK, ST_HI_ACK, ST_LO_ACK: begin
                    if (ev.scl_fall) begin
                        drive_q <= 1'b0;
                        if (state == ST_HI_ACK) begin
                            state <= ST_LO;
                        end else begin
                            state <= ST_HI;
                        end
                        if (state == ST_LO_ACK) begin
                            code_q <= {hi_q[HI_W-1:0], lo_q};
                            mode_q <= hi_q[HI_W+PD_W-1:HI_W];
                        end
                    end
                end
                default: begin
                    drive_q <= 1'b0;
                end
            endcase
        end
    end

    assign pull_low = drive_q;
    assign code     = code_q;
    assign mode     = mode_q;

    // R2
    ack_only_in_ack_slot_chk: assert property (@(posedge clk) disable iff (rst)
        drive_q |-> (state inside {ST_ADDR_ACK, ST_HI_ACK, ST_LO_ACK}));

    // R6
    code_update_timing_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(code_q) || !$stable(mode_q)) |->
            ($past(state) == ST_LO_ACK && $past(ev.scl_fall)));

    // R9
    release_on_cond_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.start || ev.stop) |=> !drive_q);

    // R3
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        bitcnt <= BITCNT_W'(BYTE_W));

endmodule

// File: rtl/i2c_dac_write_slave.sv
module i2c_dac_write_slave
    import dacw_pkg::*;
#(
    parameter int FILT_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel,
    output logic             sda_pull_low,
    output logic [DAC_W-1:0] dac_code,
    output logic [PD_W-1:0]  pd_mode
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] clean_lines;
    bus_ev_t            ev;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        dacw_line_filter #(
            .FILT_CYCLES(FILT_CYCLES)
        ) i_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_lines[g]),
            .clean(clean_lines[g])
        );
    end

    dacw_bus_events i_events (
        .clk  (clk),
        .rst  (rst),
        .scl_f(clean_lines[0]),
        .sda_f(clean_lines[1]),
        .ev   (ev)
    );

    dacw_write_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .addr_sel(addr_sel),
        .ev      (ev),
        .pull_low(sda_pull_low),
        .code    (dac_code),
        .mode    (pd_mode)
    );

endmodule

// File: tb/test_i2c_dac_write_slave.sv
module test_i2c_dac_write_slave;

    localparam int Q = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        addr_sel = 1'b0;
    logic        sda_pull_low;
    logic [11:0] dac_code;
    logic [1:0]  pd_mode;
    logic        sda_bus;

    int nchk  = 0;
    int nfail = 0;

    logic [11:0] exp_code = '0;
    logic [1:0]  exp_pd   = '0;

    always #10 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull_low;

    i2c_dac_write_slave #(.FILT_CYCLES(4)) i_i2c_dac_write_slave (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .addr_sel    (addr_sel),
        .sda_pull_low(sda_pull_low),
        .dac_code    (dac_code),
        .pd_mode     (pd_mode)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i];
            if (glitch && i == 4) begin
                wait_clk(3);
                scl_m = 1'b1; wait_clk(2);
                scl_m = 1'b0; wait_clk(Q - 5);
            end else begin
                wait_clk(Q);
            end
            scl_m = 1'b1; wait_clk(2 * Q);
            scl_m = 1'b0; wait_clk(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch,
                             output logic ack, output logic [11:0] code_mid, output logic [1:0] pd_mid);
        send_bits(b, 8, glitch);
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        ack      = sda_pull_low;
        code_mid = dac_code;
        pd_mid   = pd_mode;
        wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic write_word(input logic [7:0] hi, input logic [7:0] lo, input bit exp_ack,
                              input bit glitch, input string tag);
        logic a;
        logic [11:0] cm;
        logic [1:0]  pm;
        send_byte(hi, 1'b0, a, cm, pm);
        check(a == exp_ack, {tag, " R5 first byte ack"}, a, exp_ack);
        send_byte(lo, glitch, a, cm, pm);
        check(a == exp_ack, {tag, " R5 second byte ack"}, a, exp_ack);
        check(cm == exp_code && pm == exp_pd, {tag, " R6 held during ack"}, {cm, pm}, {exp_code, exp_pd});
        if (exp_ack) begin
            exp_code = {hi[3:0], lo};
            exp_pd   = hi[5:4];
        end
        check(dac_code == exp_code, {tag, " R5 code"}, dac_code, exp_code);
        check(pd_mode == exp_pd, {tag, " R5 mode"}, pd_mode, exp_pd);
    endtask

    task automatic do_reset(input logic sel);
        rst = 1'b1; addr_sel = sel; scl_m = 1'b1; sda_m = 1'b1;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);
        exp_code = '0;
        exp_pd   = '0;
        check(dac_code == 12'h0, "R1 code after reset", dac_code, 0);
        check(pd_mode == 2'b00, "R1 mode after reset", pd_mode, 0);
        check(sda_pull_low == 1'b0, "R1 line released", sda_pull_low, 0);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic a;
        logic [11:0] cm;
        logic [1:0]  pm;
        logic exp_a;

        do_reset(1'b0);

        // R2 R3 R4: every address byte under select bit 0
        for (int b = 0; b < 256; b++) begin
            bus_start();
            send_byte(8'(b), 1'b0, a, cm, pm);
            exp_a = (b == 8'h98) || (b == 8'h90);
            check(a == exp_a, (b == 8'h90) ? "R4 broadcast ack" : (exp_a ? "R2 own address ack" : "R3 foreign address nack"),
                  a, exp_a);
            bus_stop();
            check(sda_pull_low == 1'b0, "R9 released after stop", sda_pull_low, 0);
        end
        check(dac_code == 12'h0 && pd_mode == 2'b00, "R1 no word no change", {dac_code, pd_mode}, 0);

        // R5 R7: several words in one session
        bus_start();
        send_byte(8'h98, 1'b0, a, cm, pm);
        check(a == 1'b1, "R7 address ack", a, 1);
        for (int k = 0; k < 8; k++) begin
            logic [11:0] c;
            logic [7:0]  hi;
            c  = 12'((k * 12'h9A7 + 12'h123) & 12'hFFF);
            hi = {k[2], ~k[0], 2'(k), c[11:8]};
            write_word(hi, c[7:0], 1'b1, 1'b0, "R7 stream");
        end
        bus_stop();

        // R3: read request and foreign address ignore data
        bus_start();
        send_byte(8'h99, 1'b0, a, cm, pm);
        check(a == 1'b0, "R3 read bit nack", a, 0);
        write_word(8'h3F, 8'hFF, 1'b0, 1'b0, "R3 after read addr");
        bus_stop();
        bus_start();
        send_byte(8'h9A, 1'b0, a, cm, pm);
        check(a == 1'b0, "R3 other select nack", a, 0);
        write_word(8'h15, 8'h5A, 1'b0, 1'b0, "R3 after other addr");
        bus_stop();

        // R11: repeated START to a foreign address ends the session
        bus_start();
        send_byte(8'h98, 1'b0, a, cm, pm);
        write_word(8'h1A, 8'hBC, 1'b1, 1'b0, "R11 before restart");
        bus_start();
        send_byte(8'h9A, 1'b0, a, cm, pm);
        check(a == 1'b0, "R11 restart foreign nack", a, 0);
        write_word(8'h27, 8'h11, 1'b0, 1'b0, "R11 after restart");
        bus_stop();

        // R9: START and STOP in the middle of a word
        bus_start();
        send_byte(8'h98, 1'b0, a, cm, pm);
        send_byte(8'h3E, 1'b0, a, cm, pm);
        send_bits(8'hA5, 4, 1'b0);
        bus_start();
        check(sda_pull_low == 1'b0, "R9 released on restart", sda_pull_low, 0);
        check(dac_code == exp_code && pd_mode == exp_pd, "R9 partial word dropped on restart",
              {dac_code, pd_mode}, {exp_code, exp_pd});
        send_byte(8'h98, 1'b0, a, cm, pm);
        check(a == 1'b1, "R9 readdress ack", a, 1);
        send_byte(8'h2D, 1'b0, a, cm, pm);
        bus_stop();
        check(sda_pull_low == 1'b0, "R9 released on stop", sda_pull_low, 0);
        check(dac_code == exp_code && pd_mode == exp_pd, "R9 partial word dropped on stop",
              {dac_code, pd_mode}, {exp_code, exp_pd});
        // after the aborted word a fresh session starts with a first byte
        bus_start();
        send_byte(8'h98, 1'b0, a, cm, pm);
        write_word(8'h00, 8'h01, 1'b1, 1'b0, "R9 fresh word");
        bus_stop();

        // R8: preamble then repeated START
        bus_start();
        send_byte(8'h0B, 1'b0, a, cm, pm);
        check(a == 1'b0, "R8 preamble nack", a, 0);
        bus_start();
        send_byte(8'h98, 1'b0, a, cm, pm);
        check(a == 1'b1, "R8 address after preamble", a, 1);
        write_word(8'h2C, 8'h3D, 1'b1, 1'b0, "R8 word");
        bus_stop();

        // R10: short SCL spike inside the second byte
        bus_start();
        send_byte(8'h98, 1'b0, a, cm, pm);
        write_word(8'h37, 8'hE4, 1'b1, 1'b1, "R10 spike");
        bus_stop();

        // R1 R2 R4: select bit latched as 1, pin changed later
        do_reset(1'b1);
        addr_sel = 1'b0;
        for (int b = 8'h90; b < 8'hA0; b++) begin
            bus_start();
            send_byte(8'(b), 1'b0, a, cm, pm);
            exp_a = (b == 8'h9A) || (b == 8'h90);
            check(a == exp_a, (b == 8'h90) ? "R4 broadcast ack sel1" : "R2 latched select", a, exp_a);
            bus_stop();
        end
        bus_start();
        send_byte(8'h90, 1'b0, a, cm, pm);
        write_word(8'hD9, 8'h66, 1'b1, 1'b0, "R4 broadcast word");
        bus_stop();

        summary();
        $finish;
    end

endmodule